// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a CPU-side register window and a downstream configuration port. It turns a CPU access to the configuration window into a type-0 configuration cycle. The low 16 bits of the CPU byte address are joined with the low 16 bits of a mapping register to form a 32-bit configuration address. Bits 31:11 of that address form a one-hot device-select field. The position of the lowest set bit in that field becomes the device number. The function and register fields are copied through. The bus number comes from a static input. The packed result is issued downstream with the enable bit set.

Two kinds of request are answered locally and never reach the downstream port. The first is a request for which the mapping register marks the type-0 form as unsupported. The second is a request with an empty device-select field. For either, a read returns all ones across the access width and a write is dropped. An empty device-select field also raises a sticky error flag, which software clears. Each forwarded access is followed by a one-cycle pulse that tells the bridge to clear its received-master-abort and received-target-abort status bits.

Only one transaction is in flight at a time. The CPU holds its request until `cpu_ready` pulses, and the translator holds the downstream request until it is acknowledged.

Top module: `pcx_top`

## Requirements
- R1: The configuration address is `{map_cfg[15:0], cpu_addr[15:0]}`; the device, function, register and lane fields of every forwarded cycle are taken from it.
- R2: When `map_cfg[16]` is 1, no downstream cycle is issued. A write is dropped. A read returns ones across the access width: `cpu_size` 0 gives 0x000000FF, 1 gives 0x0000FFFF, and 2 or 3 give 0xFFFFFFFF. `abort_clr` stays low.
- R3: The device number in `dn_addr[15:11]` is the index of the lowest set bit of configuration address bits 31:11. Bit 11 maps to 0 and bit 31 maps to 20. Higher set bits are ignored.
- R4: `dn_addr[10:8]` carries configuration address bits 10:8. `dn_addr[7:2]` carries bits 7:2. `dn_addr[1:0]` is 0. `dn_lane` carries bits 1:0.
- R5: `dn_addr[31]` is 1, `dn_addr[30:24]` is 0, and `dn_addr[23:16]` equals `bus_num`.
- R6: If `map_cfg[16]` is 0 and bits 31:11 of the configuration address are all zero, the access is answered as in R2 and `err_flag` becomes 1. The flag stays at 1 until a cycle with `err_clr` high and no new error. A new error wins over a clear in the same cycle. An unsupported request as in R2 leaves the flag unchanged.
- R7: For forwarded accesses, `dn_write`, `dn_size` (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes) and `dn_wdata` equal the CPU request. For a read, `cpu_rdata` returns `dn_rdata` as captured with `dn_ack`.
- R8: `dn_valid` rises one cycle after a forwarded request is taken. It stays high with stable outputs until the cycle `dn_ack` is seen. `cpu_ready` is then a one-cycle pulse in the next cycle. `cpu_ready` and `dn_valid` are never high together.
- R9: Every forwarded access raises `abort_clr` for exactly the cycle in which its `cpu_ready` is high.
- R10: After reset, `cpu_ready`, `dn_valid`, `abort_clr` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | CPU request present, held until cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| cpu_addr | input | 16 | Byte offset within the window |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| map_cfg | input | 17 | Mapping register: bits 15:0 upper address, bit 16 type-0 unsupported |
| bus_num | input | 8 | Static bus number |
| err_clr | input | 1 | Clears err_flag |
| err_flag | output | 1 | Sticky empty-device-select error |
| abort_clr | output | 1 | Clear the received-abort status bits |
| dn_valid | output | 1 | Downstream configuration cycle request |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_write | output | 1 | Downstream write flag |
| dn_size | output | 2 | Downstream access size |
| dn_addr | output | 32 | Packed configuration address with enable bit |
| dn_lane | output | 2 | Byte offset within the dword |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |

## Verification
The request registers and the device-select encoder hold no memory across transactions. A wrong encoder result or a corrupted captured field therefore shows on `dn_addr` in the first cycle `dn_valid` is high, one cycle after the request is taken. A sequencer stuck or misdirected shows as a missing or doubled `cpu_ready`, or as a downstream cycle for a request that should have been answered locally. The bench sees this within the transaction itself. A lost or spurious error flag is only visible on later accesses, which is why the bench checks it again after an unrelated good access and after a clear.

// File: rtl/pcx_pkg.sv
// Shared types and helpers for the configuration address translator.
package pcx_pkg;
    localparam int CFG_W = 32;
    localparam int SEL_LO = 11;
    localparam int SEL_W = CFG_W - SEL_LO;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2
    } pcx_state_e;

    // All-ones read pattern for a given access size code.
    function automatic logic [CFG_W-1:0] ones_for_size(input logic [1:0] sz);
        case (sz)
            2'd0:    ones_for_size = 32'h0000_00FF;
            2'd1:    ones_for_size = 32'h0000_FFFF;
            default: ones_for_size = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/pcx_sel_enc.sv
// Lowest-set-bit encoder for the device-select field.
// Assumes W <= 2**IW; output idx is 0 when the field is empty.
module pcx_sel_enc #(
    parameter int W  = 21,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  sel,
    output logic [IW-1:0] idx,
    output logic          none
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (sel[i]) idx = i[IW-1:0];
        end
    end

    // Empty-field detect.
    assign none = ~|sel;

    // Encoder result points at a set bit.
    always_comb begin
        if (!none) begin
            AST_ENC_HIT: assert (sel[idx]); // R3
        end
    end
endmodule

// File: rtl/pcx_addr_pack.sv
// Forms the configuration address and packs the outgoing type-0 address.
// Purely combinational; assumes map_cfg and bus_num are stable per request.
module pcx_addr_pack
    import pcx_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int OFF_W = 16,
    localparam int DEV_W = $clog2(SEL_W)
) (
    input  logic [OFF_W:0]     map_cfg,
    input  logic [OFF_W-1:0]   cpu_addr,
    input  logic [BUS_W-1:0]   bus_num,
    output logic [CFG_W-1:0]   pkt_addr,
    output logic [1:0]         lane,
    output logic               unsup,
    output logic               sel_empty
);
    logic [CFG_W-1:0] cfg;
    logic [DEV_W-1:0] dev;

    // Join the mapping register with the window offset.
    assign cfg = {map_cfg[OFF_W-1:0], cpu_addr};

    pcx_sel_enc #(.W(SEL_W), .IW(DEV_W)) u_enc (
        .sel  (cfg[CFG_W-1:SEL_LO]),
        .idx  (dev),
        .none (sel_empty)
    );

    // Enable bit, reserved zeros, bus, device, function, register, dword aligned.
    assign pkt_addr = {1'b1, {(CFG_W-1-BUS_W-16){1'b0}}, bus_num, dev,
                       cfg[10:8], cfg[7:2], 2'b00};
    // Byte offset within the dword.
    assign lane  = cfg[1:0];
    // Type-0 form disabled by the mapping register.
    assign unsup = map_cfg[OFF_W];
endmodule

// File: rtl/pcx_ctrl.sv
// Transaction sequencer: captures one CPU request, forwards or answers it,
// then pulses cpu_ready. Assumes the CPU holds cpu_valid until cpu_ready.
module pcx_ctrl
    import pcx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_valid,
    input  logic             cpu_write,
    input  logic [1:0]       cpu_size,
    input  logic [CFG_W-1:0] cpu_wdata,
    output logic             cpu_ready,
    output logic [CFG_W-1:0] cpu_rdata,
    input  logic [CFG_W-1:0] pkt_addr,
    input  logic [1:0]       lane,
    input  logic             unsup,
    input  logic             sel_empty,
    input  logic             err_clr,
    output logic             err_flag,
    output logic             abort_clr,
    output logic             dn_valid,
    input  logic             dn_ack,
    output logic             dn_write,
    output logic [1:0]       dn_size,
    output logic [CFG_W-1:0] dn_addr,
    output logic [1:0]       dn_lane,
    output logic [CFG_W-1:0] dn_wdata,
    input  logic [CFG_W-1:0] dn_rdata
);
    pcx_state_e state;
    logic       take;
    logic       reject;

    assign take   = (state == ST_IDLE) && cpu_valid;
    assign reject = unsup | sel_empty;

    // Sequencer state and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            dn_addr   <= '0;
            dn_write  <= 1'b0;
            dn_size   <= '0;
            dn_wdata  <= '0;
            dn_lane   <= '0;
            cpu_rdata <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cpu_valid) begin
                        dn_addr  <= pkt_addr;
                        dn_write <= cpu_write;
                        dn_size  <= cpu_size;
                        dn_wdata <= cpu_wdata;
                        dn_lane  <= lane;
                        if (reject) begin
                            cpu_rdata <= cpu_write ? '0 : ones_for_size(cpu_size);
                            state     <= ST_RESP;
                        end else begin
                            state <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (dn_ack) begin
                        cpu_rdata <= dn_write ? '0 : dn_rdata;
                        state     <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Abort-status clear pulse, aligned with the completion of a forwarded access.
    always_ff @(posedge clk) begin
        if (!rst_n) abort_clr <= 1'b0;
        else        abort_clr <= (state == ST_ISSUE) && dn_ack;
    end

    // Sticky error flag; a new error wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                            err_flag <= 1'b0;
        else if (take && !unsup && sel_empty)  err_flag <= 1'b1;
        else if (err_clr)                      err_flag <= 1'b0;
    end

    assign dn_valid  = (state == ST_ISSUE);
    assign cpu_ready = (state == ST_RESP);

    AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ack |=> dn_valid && $stable(dn_addr) && $stable(dn_wdata)); // R8
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R8
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_valid && cpu_ready)); // R8
    AST_CLR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_clr |-> cpu_ready); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !err_clr |=> err_flag); // R6
    AST_DN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> dn_addr[31]); // R5
endmodule

// File: rtl/pcx_top.sv
// Configuration address translator top: packing logic plus sequencer.
// Assumes bus_num and map_cfg are static while a request is taken.
module pcx_top
    import pcx_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_valid,
    output logic             cpu_ready,
    input  logic             cpu_write,
    input  logic [1:0]       cpu_size,
    input  logic [OFF_W-1:0] cpu_addr,
    input  logic [CFG_W-1:0] cpu_wdata,
    output logic [CFG_W-1:0] cpu_rdata,
    input  logic [OFF_W:0]   map_cfg,
    input  logic [BUS_W-1:0] bus_num,
    input  logic             err_clr,
    output logic             err_flag,
    output logic             abort_clr,
    output logic             dn_valid,
    input  logic             dn_ack,
    output logic             dn_write,
    output logic [1:0]       dn_size,
    output logic [CFG_W-1:0] dn_addr,
    output logic [1:0]       dn_lane,
    output logic [CFG_W-1:0] dn_wdata,
    input  logic [CFG_W-1:0] dn_rdata
);
    logic [CFG_W-1:0] pkt_addr;
    logic [1:0]       lane;
    logic             unsup;
    logic             sel_empty;

    pcx_addr_pack #(.BUS_W(BUS_W), .OFF_W(OFF_W)) u_pack (
        .map_cfg   (map_cfg),
        .cpu_addr  (cpu_addr),
        .bus_num   (bus_num),
        .pkt_addr  (pkt_addr),
        .lane      (lane),
        .unsup     (unsup),
        .sel_empty (sel_empty)
    );

    pcx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_valid (cpu_valid),
        .cpu_write (cpu_write),
        .cpu_size  (cpu_size),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .pkt_addr  (pkt_addr),
        .lane      (lane),
        .unsup     (unsup),
        .sel_empty (sel_empty),
        .err_clr   (err_clr),
        .err_flag  (err_flag),
        .abort_clr (abort_clr),
        .dn_valid  (dn_valid),
        .dn_ack    (dn_ack),
        .dn_write  (dn_write),
        .dn_size   (dn_size),
        .dn_addr   (dn_addr),
        .dn_lane   (dn_lane),
        .dn_wdata  (dn_wdata),
        .dn_rdata  (dn_rdata)
    );

    AST_REJECT_NO_DN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> !dn_valid); // R6
endmodule

// File: tb/pcx_top_tb.sv
module pcx_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic        cpu_ready;
    logic        cpu_write = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic [16:0] map_cfg = '0;
    logic [7:0]  bus_num = 8'h00;
    logic        err_clr = 1'b0;
    logic        err_flag;
    logic        abort_clr;
    logic        dn_valid;
    logic        dn_ack = 1'b0;
    logic        dn_write;
    logic [1:0]  dn_size;
    logic [31:0] dn_addr;
    logic [1:0]  dn_lane;
    logic [31:0] dn_wdata;
    logic [31:0] dn_rdata = '0;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcx_top u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
        .cpu_write(cpu_write), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .map_cfg(map_cfg),
        .bus_num(bus_num), .err_clr(err_clr), .err_flag(err_flag),
        .abort_clr(abort_clr), .dn_valid(dn_valid), .dn_ack(dn_ack),
        .dn_write(dn_write), .dn_size(dn_size), .dn_addr(dn_addr),
        .dn_lane(dn_lane), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
    );

    // Vector: {map_cfg[16:0], cpu_addr[15:0], size[1:0], write, wdata[31:0]}
    localparam logic [67:0] VECS [0:NVEC-1] = '{
        {17'h0_0001, 16'h0000, 2'd2, 1'b0, 32'h0},
        {17'h0_8000, 16'h0000, 2'd1, 1'b1, 32'hCAFE_0123},
        {17'h0_0030, 16'h8A7D, 2'd0, 1'b0, 32'h0},
        {17'h0_0000, 16'h0804, 2'd2, 1'b1, 32'h1234_5678},
        {17'h1_0004, 16'h1000, 2'd0, 1'b0, 32'h0},
        {17'h1_0004, 16'h1000, 2'd1, 1'b0, 32'h0},
        {17'h1_FFFF, 16'hFFFF, 2'd3, 1'b0, 32'h0},
        {17'h1_0040, 16'h2000, 2'd2, 1'b1, 32'hDEAD_BEEF}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected packed address from the requirement text.
    function automatic logic [31:0] ref_pack(input logic [31:0] cfg, input logic [7:0] bus);
        logic [4:0] dev;
        dev = 5'd0;
        for (int i = 31; i >= 11; i--) if (cfg[i]) dev = 5'(i - 11);
        ref_pack = 32'h8000_0000 | (32'(bus) << 16) | (32'(dev) << 11)
                 | (cfg & 32'h0000_0700) | (cfg & 32'h0000_00FC);
    endfunction

    function automatic logic [31:0] ref_ones(input logic [1:0] sz);
        ref_ones = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic access(input logic [16:0] m, input logic [15:0] a, input logic [1:0] sz,
                          input logic wr, input logic [31:0] wd, input int lat,
                          input string atag);
        logic [31:0] cfg;
        logic [31:0] exp_addr;
        logic [31:0] rsp;
        logic [31:0] first_addr;
        bit fwd;
        bit seen;
        bit done;
        int waited;
        cfg = {m[15:0], a};
        fwd = !m[16] && (cfg[31:11] != 21'd0);
        exp_addr = ref_pack(cfg, bus_num);
        rsp = exp_addr ^ 32'h5A5A_A5A5;
        seen = 0; done = 0; waited = 0; first_addr = '0;
        @(negedge clk);
        map_cfg = m; cpu_addr = a; cpu_size = sz; cpu_write = wr; cpu_wdata = wd;
        cpu_valid = 1'b1;
        for (int t = 0; t < 50 && !done; t++) begin
            @(negedge clk);
            if (cpu_ready) begin
                done = 1;
                dn_ack = 1'b0;
                cpu_valid = 1'b0;
                chk(dn_valid == 1'b0, "R8", 32'(dn_valid), 32'h0);
                if (fwd) begin
                    chk(seen, "R8", 32'(seen), 32'h1);
                    chk(abort_clr == 1'b1, "R9", 32'(abort_clr), 32'h1);
                    if (!wr) chk(cpu_rdata == rsp, "R7", cpu_rdata, rsp);
                end else begin
                    chk(!seen, "R2", 32'(seen), 32'h0);
                    chk(abort_clr == 1'b0, "R2", 32'(abort_clr), 32'h0);
                    if (!wr) chk(cpu_rdata == ref_ones(sz), "R2", cpu_rdata, ref_ones(sz));
                end
            end else if (dn_valid) begin
                if (!seen) begin
                    seen = 1;
                    first_addr = dn_addr;
                    chk(dn_addr == exp_addr, atag, dn_addr, exp_addr);
                    chk(dn_addr[23:16] == bus_num && dn_addr[31:24] == 8'h80, "R5",
                        dn_addr, exp_addr);
                    chk(dn_lane == a[1:0], "R4", 32'(dn_lane), 32'(a[1:0]));
                    chk(dn_size == sz && dn_write == wr, "R7",
                        {29'd0, dn_write, dn_size}, {29'd0, wr, sz});
                    if (wr) chk(dn_wdata == wd, "R7", dn_wdata, wd);
                end else begin
                    chk(dn_addr == first_addr, "R8", dn_addr, first_addr);
                end
                if (waited >= lat) begin
                    dn_ack = 1'b1;
                    dn_rdata = rsp;
                end
                waited++;
            end
        end
        if (!done) chk(0, "R8", 32'h0, 32'h1);
        dn_ack = 1'b0;
        cpu_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!cpu_ready && !dn_valid && !abort_clr && !err_flag, "R10",
            {28'd0, cpu_ready, dn_valid, abort_clr, err_flag}, 32'h0);
        rst_n = 1'b1;
        bus_num = 8'h3C;

        // Table of mixed vectors, R1 address formation
        for (int v = 0; v < NVEC; v++) begin
            access(VECS[v][67:51], VECS[v][50:35], VECS[v][34:33], VECS[v][32],
                   VECS[v][31:0], v % 3, "R1");
        end

        // R3: every device-select position, with an extra higher bit on some
        for (int p = 0; p < 21; p++) begin
            logic [31:0] cfg;
            cfg = 32'h1 << (p + 11);
            if (p < 20 && p[0]) cfg[31] = 1'b1;
            cfg[10:0] = 11'(p * 37 + 5);
            bus_num = 8'(p * 11);
            access({1'b0, cfg[31:16]}, cfg[15:0], 2'(p % 3), p[1], 32'(p) * 32'h0101_0101,
                   p % 2, "R3");
            // Same position with the type-0 form disabled
            access({1'b1, cfg[31:16]}, cfg[15:0], 2'(p % 3), 1'b0, 32'h0, 0, "R2");
        end

        // R6: empty device-select field sets the sticky flag
        chk(err_flag == 1'b0, "R6", 32'(err_flag), 32'h0);
        access(17'h0_0000, 16'h07FC, 2'd1, 1'b0, 32'h0, 0, "R6");
        chk(err_flag == 1'b1, "R6", 32'(err_flag), 32'h1);
        access(17'h0_0002, 16'h0100, 2'd2, 1'b0, 32'h0, 1, "R4");
        chk(err_flag == 1'b1, "R6", 32'(err_flag), 32'h1);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk(err_flag == 1'b0, "R6", 32'(err_flag), 32'h0);
        // Unsupported with empty field: flag untouched
        access(17'h1_0000, 16'h0000, 2'd0, 1'b0, 32'h0, 0, "R2");
        chk(err_flag == 1'b0, "R6", 32'(err_flag), 32'h0);
        // Empty-field write is dropped
        access(17'h0_0000, 16'h0003, 2'd0, 1'b1, 32'hFFFF_0000, 0, "R6");
        chk(err_flag == 1'b1, "R6", 32'(err_flag), 32'h1);

        // R10: reset mid-run clears the flag
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(!err_flag && !cpu_ready && !dn_valid, "R10",
            {29'd0, err_flag, cpu_ready, dn_valid}, 32'h0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule